// File: doc/BRIEF.md
# Two-Cycle Accumulating Calculator

This block is a small sequential arithmetic unit that keeps one stored result and combines it with a fresh operand each time it works. A 2-bit operation select picks add, subtract, multiply or unsigned divide. The stored result is always the left-hand operand, and each new result replaces it. A chain of operations therefore runs without the caller ever supplying the running value.

The work is split over two register stages. The input stage samples the operand and the op select. The accumulator stage computes from the stored result and holds the outcome. An internal phase bit toggles on every clock, so only every other edge takes inputs. The result of those inputs shows on the output in the following cycle, qualified by `valid_o`. In the cycles between, the output reads zero and the stored result is held. Because inputs are taken only every second cycle, each result is written back before the next calculation reads it, and no forwarding is needed.

Top module: `acc_calc`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `valid_o` is 0 and `result_o` is 0. Reset clears the stored result to 0.
- R2: `valid_o` alternates on every clock edge after reset. It is low after the 1st rising edge following reset release, high after the 2nd, low after the 3rd, and so on.
- R3: Inputs are taken on even-numbered edges after reset release (2nd, 4th, ...). The result computed from them is on `result_o`, with `valid_o` high, during the cycle that follows that edge.
- R4: Op select 2'b00 gives stored + operand, modulo 2^W.
- R5: Op select 2'b01 gives stored − operand, modulo 2^W.
- R6: Op select 2'b10 gives the low W bits of stored × operand.
- R7: Op select 2'b11 gives the unsigned quotient stored / operand, rounded toward zero, when the operand is nonzero.
- R8: Op select 2'b11 with an operand of 0 gives all ones.
- R9: `result_o` reads 0 in every cycle where `valid_o` is low.
- R10: Operand and op values present on odd-numbered edges are ignored. They change neither the stored result nor any later output.
- R11: Each result shown with `valid_o` high becomes the stored result, and it is the left-hand operand of the next calculation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | W | Right-hand operand |
| op_i | input | 2 | Operation select: 00 add, 01 sub, 10 mul, 11 unsigned div |
| result_o | output | W | Result during valid cycles, zero otherwise |
| valid_o | output | 1 | High in cycles that carry a result |

## Verification
The checker watches several properties on every cycle:
- `valid_o` alternates, and it follows the internal phase.
- The output is zero whenever `valid_o` is low.
- The stored result stays unchanged across idle cycles and equals the last valid output.
- A divide by zero yields all ones.

The arithmetic of each operation, the even-edge timing after reset, and the fact that odd-edge inputs have no effect can only be shown by the bench's scenarios. The bench sweeps every op against a spread of operands, drives junk on the ignored edges, and compares each result against a reference accumulator.

// File: rtl/calc_pkg.sv
package calc_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } calc_op_e;
endpackage

// File: rtl/calc_phase.sv
module calc_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  logic phase_q;

  // low after reset, so the first take is on the second edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/calc_in_stage.sv
module calc_in_stage #(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [W-1:0]     operand_i,
  input  calc_pkg::calc_op_e op_i,
  output logic [W-1:0]     operand_o,
  output calc_pkg::calc_op_e op_o,
  output logic             vld_o
);
  logic [W-1:0]       opnd_q;
  calc_pkg::calc_op_e op_q;
  logic               vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_q <= '0;
      op_q   <= calc_pkg::OP_ADD;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take_i;
      // hold operands on idle edges
      if (take_i) begin
        opnd_q <= operand_i;
        op_q   <= op_i;
      end
    end
  end

  assign operand_o = opnd_q;
  assign op_o      = op_q;
  assign vld_o     = vld_q;
endmodule

// File: rtl/calc_alu.sv
module calc_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]       lhs_i,
  input  logic [W-1:0]       rhs_i,
  input  calc_pkg::calc_op_e op_i,
  output logic [W-1:0]       res_o
);
  localparam logic [W-1:0] AllOnes = {W{1'b1}};

  always_comb begin
    unique case (op_i)
      calc_pkg::OP_ADD: res_o = lhs_i + rhs_i;
      calc_pkg::OP_SUB: res_o = lhs_i - rhs_i;
      calc_pkg::OP_MUL: res_o = lhs_i * rhs_i;
      calc_pkg::OP_DIV: res_o = (rhs_i == '0) ? AllOnes : (lhs_i / rhs_i);
      default:          res_o = '0;
    endcase
  end
endmodule

// File: rtl/calc_acc.sv
module calc_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] res_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] result_o,
  output logic         valid_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (vld_i) acc_q <= res_i;
  end

  assign acc_o    = acc_q;
  assign result_o = vld_i ? res_i : '0;
  assign valid_o  = vld_i;
endmodule

// File: rtl/acc_calc.sv
module acc_calc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] operand_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         valid_o
);
  logic               phase;
  logic [W-1:0]       opnd_q;
  calc_pkg::calc_op_e op_q;
  logic               stg_vld;
  logic [W-1:0]       acc_q;
  logic [W-1:0]       alu_res;

  calc_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  calc_in_stage #(.W(W)) u_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (phase),
    .operand_i(operand_i),
    .op_i     (calc_pkg::calc_op_e'(op_i)),
    .operand_o(opnd_q),
    .op_o     (op_q),
    .vld_o    (stg_vld)
  );

  calc_alu #(.W(W)) u_alu (
    .lhs_i(acc_q),
    .rhs_i(opnd_q),
    .op_i (op_q),
    .res_o(alu_res)
  );

  calc_acc #(.W(W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (stg_vld),
    .res_i   (alu_res),
    .acc_o   (acc_q),
    .result_o(result_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/acc_calc_chk.sv
module acc_calc_chk #(
  parameter int unsigned W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               phase_i,
  input logic               valid_o,
  input logic [W-1:0]       result_o,
  input logic [W-1:0]       acc_i,
  input logic [W-1:0]       opnd_i,
  input calc_pkg::calc_op_e op_i
);
  a_r2_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r3_phase_to_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> valid_o);

  a_r9_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0));

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> $stable(acc_i));

  a_r11_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o) |-> (acc_i == $past(result_o)));

  a_r8_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_i == calc_pkg::OP_DIV && opnd_i == '0) |-> (result_o == {W{1'b1}}));
endmodule

bind acc_calc acc_calc_chk #(.W(W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .phase_i (phase),
  .valid_o (valid_o),
  .result_o(result_o),
  .acc_i   (acc_q),
  .opnd_i  (opnd_q),
  .op_i    (op_q)
);

// File: tb/acc_calc_tb.sv
`timescale 1ns/1ps
module acc_calc_tb_top;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] operand_i = '0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] result_o;
  logic         valid_o;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  bit done = 1'b0;
  logic [W-1:0] model_acc = '0;

  always #5 clk_i = ~clk_i;

  acc_calc #(.W(W)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .operand_i(operand_i),
    .op_i     (op_i),
    .result_o (result_o),
    .valid_o  (valid_o)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_op(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [1:0] op);
    case (op)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return a * b;
      default: return (b == 0) ? {W{1'b1}} : a / b;
    endcase
  endfunction

  function automatic string op_req(input logic [1:0] op, input logic [W-1:0] b);
    case (op)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return (b == 0) ? "R8" : "R7";
    endcase
  endfunction

  // called at a negedge; drives, takes one edge, checks at the next negedge
  task automatic step(input logic [1:0] op, input logic [W-1:0] v);
    logic [W-1:0] exp;
    op_i = op;
    operand_i = v;
    @(posedge clk_i);
    edge_n++;
    @(negedge clk_i);
    if (edge_n % 2 == 0) begin
      exp = ref_op(model_acc, v, op);
      check(valid_o == 1'b1, "R3", {{(W-1){1'b0}}, valid_o}, 1);
      // R11 and R10: model_acc only changes on taken edges
      check(result_o == exp, op_req(op, v), result_o, exp);
      model_acc = exp;
    end else begin
      check(valid_o == 1'b0, "R2", {{(W-1){1'b0}}, valid_o}, 0);
      check(result_o == '0, "R9", result_o, '0);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0 && result_o == '0, "R1", result_o, '0);
    rst_ni = 1'b1;
    edge_n = 0;
    model_acc = '0;
  endtask

  initial begin
    logic [W-1:0] vals [12];
    vals[0] = 32'h0;          vals[1] = 32'h1;
    vals[2] = 32'h2;          vals[3] = 32'h3;
    vals[4] = 32'hFFFF_FFFF;  vals[5] = 32'h8000_0000;
    vals[6] = 32'h7;          vals[7] = 32'h1234_5678;
    vals[8] = 32'h0001_0000;  vals[9] = 32'hDEAD_BEEF;
    vals[10] = 32'h5;         vals[11] = 32'h0000_0100;

    @(negedge clk_i);
    do_reset();
    // first edge after release is idle (R2), second takes (R3)
    step(2'b11, 32'hAAAA_5555);
    step(2'b00, 32'd45);

    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 12; k++) begin
        // odd edge: junk inputs that must be ignored (R10)
        step(2'(3 - op), ~vals[k] ^ 32'h5A5A_0F0F);
        step(2'(op), vals[k]);
      end
      // refill stored value so divides and multiplies stay interesting
      step(2'b10, 32'h0);
      step(2'b00, 32'h9876_5432 + 32'(op));
    end

    // chained accumulation 1..9 (R11)
    for (int k = 1; k <= 9; k++) begin
      step(2'b01, 32'hFFFF_FFFF);
      step(2'b00, 32'(k));
    end

    // mid-run reset clears the stored value (R1)
    do_reset();
    step(2'b00, 32'h1);
    step(2'b00, 32'h11);
    check(result_o == 32'h11, "R1", result_o, 32'h11);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule